// File: doc/BRIEF.md
# Reloadable Interval Timer

This block is a 16-bit down-counting interval timer with a single interrupt request. Software loads a reload value one byte at a time through a small byte-wide register port. Writing the upper byte starts a countdown. When the countdown expires, the timer raises its interrupt. It then either stops or restarts with a steady period, depending on a mode input.

The count is visible while it runs. It falls by one every eight clocks. The first expiry after a start includes a fixed extra delay that later reloads do not have. Reading the low byte of the count acknowledges the interrupt. Reading the high byte does not. The request is also presented as one bit of an interrupt-source vector, at a fixed slot, for an external controller.

Top module: `reload_timer`

## Requirements
- R1: After reset, `irq` is 0, `irq_vec` is all zeros, `acc_rdata` is 0, the reload value is 0 and the timer is stopped (the count reads 0).
- R2: A write with `acc_addr`=0 replaces only bits 7:0 of the reload value. It starts nothing, leaves `irq` unchanged and does not disturb a countdown in progress.
- R3: A write with `acc_addr`=1 replaces bits 15:8 of the reload value, clears `irq` on that edge and starts a countdown. A count low-byte read on the following edge returns the low byte of reload+1.
- R4: With reload value L, `irq` rises on the clock edge that comes L*8+12 edges after the edge that accepted the starting write.
- R5: When `auto_reload` is 1 at an expiry edge, the countdown restarts so that the next expiry follows (L+2)*8 edges later, where L is the reload value held at that expiry.
- R6: When `auto_reload` is 0 at an expiry edge, the timer stops. The count reads 0 and `irq` stays set until it is acknowledged or a new start occurs.
- R7: A read (`acc_en`=1, `acc_wr`=0) puts a byte of the count on `acc_rdata` one edge later. `acc_addr`=0 selects bits 7:0 and clears `irq`. `acc_addr`=1 selects bits 15:8 and leaves `irq` unchanged.
- R8: The readable count equals the remaining clock ticks divided by 8, rounded down and saturated at 16'hFFFF. It never increases except at a start or a reload.
- R9: `irq_vec` carries `irq` at bit 5 and zero in every other bit.
- R10: When an expiry and a count low-byte read share an edge, `irq` ends set. When an expiry and a starting write share an edge, the start wins: `irq` ends clear and a fresh first period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| acc_wdata | input | 8 | Write data |
| auto_reload | input | 1 | 1 = restart after expiry, 0 = stop after expiry |
| acc_rdata | output | 8 | Registered read data (count byte) |
| irq | output | 1 | Timer interrupt request |
| irq_vec | output | 8 | Interrupt-source vector with the request at bit 5 |

## Verification
Every result of this block lands a fixed number of edges after its cause. Read data and interrupt clears appear one edge after the access. The first expiry comes L*8+12 edges after the starting write, and each reload expiry comes (L+2)*8 edges after the previous one. A tick-accurate reference model in the bench steps once per rising edge, and all outputs are compared against it at every falling edge, so any slip of a single cycle shows up at once. Directed checks then count falling edges from the return of each access to the rise of `irq`, and compare that count with the formula. The two same-edge collisions are placed exactly on the expiry edge.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  // Kinds of register access seen on the byte port.
  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_LATCH_LO,
    ACC_LATCH_HI,
    ACC_CNT_LO,
    ACC_CNT_HI
  } acc_kind_t;

  // Classify one cycle of the access port.
  function automatic acc_kind_t decode_access(input logic en, input logic wr, input logic hi);
    acc_kind_t k;
    if (!en)
      k = ACC_IDLE;
    else if (wr)
      k = hi ? ACC_LATCH_HI : ACC_LATCH_LO;
    else
      k = hi ? ACC_CNT_HI : ACC_CNT_LO;
    return k;
  endfunction

endpackage

// File: rtl/itmr_access.sv
module itmr_access #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_en,
  input  logic                  acc_wr,
  input  logic                  acc_addr,
  input  logic [BYTE_W-1:0]     acc_wdata,
  output logic [2*BYTE_W-1:0]   latch_o,
  output logic [2*BYTE_W-1:0]   start_latch_o,
  output logic                  start_o,
  output logic                  rd_lo_o,
  output logic                  rd_hi_o
);
  import itmr_pkg::*;

  localparam int LW = 2 * BYTE_W;

  acc_kind_t        kind_w;
  logic [LW-1:0]    latch_q;

  assign kind_w = decode_access(acc_en, acc_wr, acc_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else begin
      case (kind_w)
        ACC_LATCH_LO: latch_q[BYTE_W-1:0]  <= acc_wdata;
        ACC_LATCH_HI: latch_q[LW-1:BYTE_W] <= acc_wdata;
        default:      latch_q              <= latch_q;
      endcase
    end
  end

  // The start uses the freshly written high byte together with the held low byte.
  assign start_latch_o = {acc_wdata, latch_q[BYTE_W-1:0]};
  assign latch_o       = latch_q;
  assign start_o       = (kind_w == ACC_LATCH_HI);
  assign rd_lo_o       = (kind_w == ACC_CNT_LO);
  assign rd_hi_o       = (kind_w == ACC_CNT_HI);

  AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_w == ACC_LATCH_LO) |=> $stable(latch_q[LW-1:BYTE_W])); // R2

  AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_w == ACC_LATCH_HI) |=> $stable(latch_q[BYTE_W-1:0])); // R3

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, rd_lo_o, rd_hi_o})); // R7

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W       = 16,
  parameter int PRE_SHIFT   = 3,
  parameter int FIRST_EXTRA = 12,
  parameter int REARM_EXTRA = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] start_latch_i,
  input  logic [CNT_W-1:0] latch_i,
  input  logic             rearm_i,
  output logic             expire_o,
  output logic             running_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int TW = CNT_W + PRE_SHIFT + 1;
  typedef logic [TW-1:0] tick_t;
  localparam tick_t TICK_ONE = tick_t'(1);
  localparam tick_t CNT_MAX  = tick_t'({CNT_W{1'b1}});

  // Ticks until the first expiry after a start.
  function automatic tick_t first_ticks(input logic [CNT_W-1:0] l);
    return (tick_t'(l) << PRE_SHIFT) + tick_t'(FIRST_EXTRA);
  endfunction

  // Ticks between expiries while reloading.
  function automatic tick_t rearm_ticks(input logic [CNT_W-1:0] l);
    return (tick_t'(l) + tick_t'(REARM_EXTRA)) << PRE_SHIFT;
  endfunction

  // Software-visible count: prescaled remaining ticks, saturated.
  function automatic logic [CNT_W-1:0] visible_count(input tick_t t);
    tick_t s;
    s = t >> PRE_SHIFT;
    if (s > CNT_MAX)
      return '1;
    return s[CNT_W-1:0];
  endfunction

  tick_t ticks_q;
  tick_t ticks_d;

  assign expire_o  = (ticks_q == TICK_ONE);
  assign running_o = (ticks_q != '0);
  assign count_o   = visible_count(ticks_q);

  always_comb begin
    if (start_i)
      ticks_d = first_ticks(start_latch_i);
    else if (expire_o)
      ticks_d = rearm_i ? rearm_ticks(latch_i) : '0;
    else if (running_o)
      ticks_d = ticks_q - TICK_ONE;
    else
      ticks_d = ticks_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ticks_q <= '0;
    else
      ticks_q <= ticks_d;
  end

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> running_o); // R3

  AST_REARM_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && rearm_i && !start_i) |=> (running_o && !expire_o)); // R5

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !rearm_i && !start_i) |=> (!running_o && count_o == '0)); // R6

  AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !expire_o) |=> (count_o <= $past(count_o))); // R8

endmodule

// File: rtl/itmr_irq.sv
module itmr_irq #(
  parameter int SRC_COUNT = 8,
  parameter int SRC_NUM   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_i,
  input  logic                 clr_i,
  input  logic                 ack_i,
  output logic                 irq_o,
  output logic [SRC_COUNT-1:0] irq_vec_o
);

  logic irq_q;

  // A start clears; an expiry beats an acknowledge on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n)
      irq_q <= 1'b0;
    else if (clr_i)
      irq_q <= 1'b0;
    else if (set_i)
      irq_q <= 1'b1;
    else if (ack_i)
      irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  for (genvar g = 0; g < SRC_COUNT; g++) begin : g_slot
    if (g == SRC_NUM) begin : g_live
      assign irq_vec_o[g] = irq_q;
    end else begin : g_tied
      assign irq_vec_o[g] = 1'b0;
    end
  end

  AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_vec_o)); // R9

  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> irq_o); // R10

  AST_CLR_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !irq_o); // R10

endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int CNT_W       = 16,
  parameter int PRE_SHIFT   = 3,
  parameter int FIRST_EXTRA = 12,
  parameter int REARM_EXTRA = 2,
  parameter int SRC_COUNT   = 8,
  parameter int SRC_NUM     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_en,
  input  logic                   acc_wr,
  input  logic                   acc_addr,
  input  logic [CNT_W/2-1:0]     acc_wdata,
  input  logic                   auto_reload,
  output logic [CNT_W/2-1:0]     acc_rdata,
  output logic                   irq,
  output logic [SRC_COUNT-1:0]   irq_vec
);

  localparam int BYTE_W = CNT_W / 2;

  logic [CNT_W-1:0]  latch_w;
  logic [CNT_W-1:0]  start_latch_w;
  logic              start_w;
  logic              rd_lo_w;
  logic              rd_hi_w;
  logic              expire_w;
  logic              running_w;
  logic [CNT_W-1:0]  count_w;
  logic [BYTE_W-1:0] rdata_q;

  itmr_access #(.BYTE_W(BYTE_W)) u_access (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_en        (acc_en),
    .acc_wr        (acc_wr),
    .acc_addr      (acc_addr),
    .acc_wdata     (acc_wdata),
    .latch_o       (latch_w),
    .start_latch_o (start_latch_w),
    .start_o       (start_w),
    .rd_lo_o       (rd_lo_w),
    .rd_hi_o       (rd_hi_w)
  );

  itmr_counter #(
    .CNT_W       (CNT_W),
    .PRE_SHIFT   (PRE_SHIFT),
    .FIRST_EXTRA (FIRST_EXTRA),
    .REARM_EXTRA (REARM_EXTRA)
  ) u_counter (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_w),
    .start_latch_i (start_latch_w),
    .latch_i       (latch_w),
    .rearm_i       (auto_reload),
    .expire_o      (expire_w),
    .running_o     (running_w),
    .count_o       (count_w)
  );

  itmr_irq #(
    .SRC_COUNT (SRC_COUNT),
    .SRC_NUM   (SRC_NUM)
  ) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (expire_w),
    .clr_i     (start_w),
    .ack_i     (rd_lo_w),
    .irq_o     (irq),
    .irq_vec_o (irq_vec)
  );

  // Registered read data: the count as it stands before the read edge.
  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (rd_lo_w)
      rdata_q <= count_w[BYTE_W-1:0];
    else if (rd_hi_w)
      rdata_q <= count_w[CNT_W-1 -: BYTE_W];
  end

  assign acc_rdata = rdata_q;

  AST_WRHI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_addr) |=> !irq); // R3

  AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(expire_w)); // R4

  AST_RDHI_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_addr && irq) |=> irq); // R7

  AST_RDLO_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && !acc_addr && !expire_w) |=> !irq); // R7

  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_w && !start_w) |=> !running_w); // R6

endmodule

// File: tb/reload_timer_tb_top.sv
`timescale 1ns/1ps
module reload_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0;
  logic       acc_wr = 1'b0;
  logic       acc_addr = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic       auto_reload = 1'b0;
  logic [7:0] acc_rdata;
  logic       irq;
  logic [7:0] irq_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reload_timer dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_en      (acc_en),
    .acc_wr      (acc_wr),
    .acc_addr    (acc_addr),
    .acc_wdata   (acc_wdata),
    .auto_reload (auto_reload),
    .acc_rdata   (acc_rdata),
    .irq         (irq),
    .irq_vec     (irq_vec)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model: remaining ticks as an integer -------------
  int m_ticks = 0;
  int m_latch = 0;
  int m_rdata = 0;
  bit m_irq   = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ticks = 0; m_latch = 0; m_rdata = 0; m_irq = 1'b0;
    end else begin
      int  cnt;
      int  nl;
      bit  hit;
      hit = (m_ticks == 1);
      cnt = m_ticks / 8;
      if (cnt > 65535) cnt = 65535;
      if (acc_en && !acc_wr)
        m_rdata = acc_addr ? (cnt / 256) % 256 : cnt % 256;
      if (acc_en && acc_wr && acc_addr) begin
        nl      = int'(acc_wdata) * 256 + (m_latch % 256);
        m_latch = nl;
        m_ticks = nl * 8 + 12;
        m_irq   = 1'b0;
      end else begin
        if (hit) begin
          m_irq   = 1'b1;
          m_ticks = auto_reload ? (m_latch + 2) * 8 : 0;
        end else if (m_ticks > 0) begin
          m_ticks = m_ticks - 1;
        end
        if (acc_en && !acc_wr && !acc_addr && !hit) m_irq = 1'b0;
        if (acc_en && acc_wr && !acc_addr)
          m_latch = (m_latch / 256) * 256 + int'(acc_wdata);
      end
    end
  end

  // Compare every cycle, half a period after the edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5", "irq vs model", int'(irq), int'(m_irq));
      chk("R9", "irq_vec vs model", int'(irq_vec), m_irq ? 32 : 0);
      chk("R8", "rdata vs model", int'(acc_rdata), m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic acc(input bit wr, input bit hi, input logic [7:0] d);
    acc_en = 1'b1; acc_wr = wr; acc_addr = hi; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; acc_addr = 1'b0; acc_wdata = 8'h00;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  int n;

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "irq after reset", int'(irq), 0);
    chk("R1", "irq_vec after reset", int'(irq_vec), 0);
    chk("R1", "rdata after reset", int'(acc_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    acc(1'b0, 1'b0, 8'h00);
    chk("R1", "count low after reset", int'(acc_rdata), 0);
    acc(1'b0, 1'b1, 8'h00);
    chk("R1", "count high after reset", int'(acc_rdata), 0);

    // R3: start with 0x0123, read count right after
    auto_reload = 1'b0;
    acc(1'b1, 1'b0, 8'h23);
    chk("R2", "low write does not start", int'(irq), 0);
    acc(1'b1, 1'b1, 8'h01);
    acc(1'b0, 1'b0, 8'h00);
    chk("R3", "count low after start", int'(acc_rdata), 8'h24);
    acc(1'b0, 1'b1, 8'h00);
    chk("R3", "count high after start", int'(acc_rdata), 8'h01);
    acc(1'b1, 1'b0, 8'h55);            // R2: low write while running
    wait_irq(n);
    chk("R4", "first expiry delay 0x123", n, 16'h0123 * 8 + 12 - 3);
    chk("R9", "vector slot 5", int'(irq_vec), 32);

    // R6 / R7: one-shot stop, high read keeps irq, low read clears it
    acc(1'b0, 1'b1, 8'h00);
    chk("R6", "count high after one-shot", int'(acc_rdata), 0);
    chk("R7", "high read keeps irq", int'(irq), 1);
    acc(1'b0, 1'b0, 8'h00);
    chk("R6", "count low after one-shot", int'(acc_rdata), 0);
    chk("R7", "low read clears irq", int'(irq), 0);
    repeat (40) @(negedge clk);
    chk("R6", "stays stopped", int'(irq), 0);

    // R2: latch low byte 0x55 survives; start with high 0x00 gives 0x0055
    acc(1'b1, 1'b1, 8'h00);
    wait_irq(n);
    chk("R2", "start uses kept low byte", n, 8'h55 * 8 + 12);
    acc(1'b0, 1'b0, 8'h00);

    // R5: reload period
    auto_reload = 1'b1;
    acc(1'b1, 1'b0, 8'h03);
    acc(1'b1, 1'b1, 8'h00);
    wait_irq(n);
    chk("R4", "first expiry delay 3", n, 36);
    acc(1'b0, 1'b0, 8'h00);
    chk("R7", "ack clears irq", int'(irq), 0);
    wait_irq(n);
    chk("R5", "second expiry", n, 39);
    acc(1'b0, 1'b0, 8'h00);
    wait_irq(n);
    chk("R5", "third expiry", n, 39);
    auto_reload = 1'b0;

    // R10: expiry and low read on the same edge
    acc(1'b1, 1'b0, 8'h02);
    acc(1'b1, 1'b1, 8'h00);
    repeat (27) @(negedge clk);
    acc(1'b0, 1'b0, 8'h00);
    chk("R10", "expiry beats ack", int'(irq), 1);
    chk("R10", "count at expiry edge", int'(acc_rdata), 0);

    // R10: expiry and start on the same edge
    acc(1'b1, 1'b1, 8'h00);
    repeat (27) @(negedge clk);
    acc(1'b1, 1'b1, 8'h00);
    chk("R10", "start beats expiry", int'(irq), 0);
    wait_irq(n);
    chk("R10", "fresh first period", n, 28);
    acc(1'b0, 1'b0, 8'h00);

    // R8: saturation and mid-count value
    acc(1'b1, 1'b0, 8'hFF);
    acc(1'b1, 1'b1, 8'hFF);
    acc(1'b0, 1'b0, 8'h00);
    chk("R8", "saturated low", int'(acc_rdata), 8'hFF);
    acc(1'b0, 1'b1, 8'h00);
    chk("R8", "saturated high", int'(acc_rdata), 8'hFF);
    acc(1'b1, 1'b0, 8'h10);
    acc(1'b1, 1'b1, 8'h00);
    repeat (20) @(negedge clk);
    acc(1'b0, 1'b0, 8'h00);
    chk("R8", "count mid-run", int'(acc_rdata), 15);
    wait_irq(n);
    chk("R4", "expiry after mid read", n, 16 * 8 + 12 - 21);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule